// File: doc/BRIEF.md
# Storage Interrupt Entry Unit

This unit prepares entry into the two storage-fault interrupts of a 32-bit core: the instruction-side fault raised by the fetch path and the data-side fault raised by the load/store path. Each cycle it may receive a strobed set of one-cycle fault flags from either side. It decides whether an interrupt is taken and which cause applies. It then produces the handler address, the machine state the handler runs with, the syndrome word and, for data faults, the captured faulting address.

The handler address is formed from the upper half of the vector prefix register and the offset register belonging to the interrupt. For instruction faults, four causes are told apart: access-control violation, precise bus-error termination, byte-ordering faults and misaligned change-of-flow targets. The syndrome encoding names the cause that won. All results are registered and come with a one-cycle taken pulse. Cycles that carry no qualifying cause leave every output register untouched.

Top module: `stg_irq_entry`

## Requirements
- R1: The vector is {ivpr[31:16], ivor[15:4], 4'b0000}, using `ivor_isi` for instruction faults and `ivor_dsi` for data faults.
- R2: With `i_vld` high, `i_acc_viol` raises an instruction fault with no cause bit set in the syndrome.
- R3: `i_bus_err` raises an instruction fault with syndrome bit 0 (external termination) only when `msr_in[15]` (external interrupt enable) is 1. When that bit is 0, the flag alone is ignored.
- R4: A byte-ordering instruction fault sets syndrome bit 17. It is raised by `i_bo_cross`, or by `i_page_vle` and `i_page_le` both high.
- R5: `i_cof_odd` raises a misaligned-fetch fault with syndrome bit 1 only when `i_page_vle` is 0. On a variable-length page it is ignored.
- R6: When several instruction causes are present, only the highest ranked one is encoded. The ranking is access control, then bus error, then byte ordering, then misaligned fetch.
- R7: The syndrome has bit 5 equal to the faulting side's variable-length-instruction flag and bit 23 equal to `d_store` for data faults only. Its cause bit is set as in R3–R5 and R9, and all other bits are 0.
- R8: On entry, `msr_out` equals `msr_in` with bits 26, 25, 18, 15, 14, 13, 11, 9, 8, 5, 4 and 1 cleared. All other bits, including machine-check enable at bit 12, are kept.
- R9: With `d_vld` high, `d_acc_viol` or `d_bo_fault` raises a data fault and loads `dear_out` with `d_ea`. A byte-ordering data fault sets syndrome bit 17 unless `d_acc_viol` is also high.
- R10: If a data fault and an instruction fault qualify in the same cycle, the data fault is taken and `took_data` is 1. `took_data` is 0 for an instruction fault.
- R11: `taken` pulses high, and all outputs update, one cycle after the strobe that carried a qualifying cause.
- R12: A cycle without a qualifying cause keeps `taken` low and leaves the vector, state, syndrome, side flag and `dear_out` unchanged. `dear_out` also holds across instruction faults.
- R13: Synchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_vld | input | 1 | Instruction-side fault flags valid |
| i_acc_viol | input | 1 | Execute access-control violation |
| i_bus_err | input | 1 | Fetch ended with error termination |
| i_bo_cross | input | 1 | Misaligned instruction crosses into page with different encoding attribute |
| i_page_vle | input | 1 | Fetch page uses variable-length encoding |
| i_page_le | input | 1 | Fetch page is little-endian |
| i_cof_odd | input | 1 | Change of flow to an odd halfword target |
| i_vle_insn | input | 1 | Faulting instruction is variable-length |
| d_vld | input | 1 | Data-side fault flags valid |
| d_acc_viol | input | 1 | Data access-control violation |
| d_bo_fault | input | 1 | Data byte-ordering violation |
| d_store | input | 1 | Faulting access is a store |
| d_vle_insn | input | 1 | Faulting load/store is variable-length |
| d_ea | input | 32 | Data effective address |
| msr_in | input | 32 | Current machine state |
| ivpr | input | 32 | Vector prefix register |
| ivor_dsi | input | 32 | Data fault offset register |
| ivor_isi | input | 32 | Instruction fault offset register |
| taken | output | 1 | Interrupt taken pulse |
| took_data | output | 1 | Last taken interrupt was the data fault |
| vector | output | 32 | Handler address |
| msr_out | output | 32 | Machine state for the handler |
| esr_out | output | 32 | Syndrome value |
| dear_out | output | 32 | Captured data fault address |

## Verification
A data fault and an instruction fault can qualify in the same cycle, and the arbitration between them is the overlap that matters most. The bench forces this with a directed cycle in which both strobes carry causes. Random traffic also raises both strobes at once often. In these cycles it checks that `took_data` is set, that the vector comes from the data offset register and that `dear_out` is loaded. It also checks that the syndrome carries only the data cause and not the competing fetch cause. Within the fetch side, all four causes are asserted together to check the ranking.

// File: rtl/stg_irq_pkg.sv
package stg_irq_pkg;
  localparam int XLEN = 32;

  // Machine state bit positions (index 0 = least significant)
  localparam int MSR_EE = 15;
  localparam int MSR_ME = 12;
  localparam int MSR_NCLR = 12;
  localparam int MSR_CLR_IDX [MSR_NCLR] = '{26, 25, 18, 15, 14, 13, 11, 9, 8, 5, 4, 1};

  // Syndrome bit positions
  localparam int ESR_ST  = 23;
  localparam int ESR_BO  = 17;
  localparam int ESR_VLI = 5;
  localparam int ESR_MIF = 1;
  localparam int ESR_XTE = 0;

  // Vector field slices
  localparam int PFX_LO = 16;
  localparam int OFS_HI = 15;
  localparam int OFS_LO = 4;

  typedef enum logic [2:0] {
    CAUSE_NONE,
    CAUSE_ACC,
    CAUSE_XTE,
    CAUSE_BO,
    CAUSE_MIF
  } cause_e;

  function automatic logic [XLEN-1:0] msr_clr_mask();
    logic [XLEN-1:0] m;
    m = '0;
    for (int k = 0; k < MSR_NCLR; k++) m[MSR_CLR_IDX[k]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/stg_isi_prio.sv
module stg_isi_prio
  import stg_irq_pkg::*;
(
  input  logic   ee,
  input  logic   acc_viol,
  input  logic   bus_err,
  input  logic   bo_cross,
  input  logic   page_vle,
  input  logic   page_le,
  input  logic   cof_odd,
  output cause_e cause
);
  logic hit_xte, hit_bo, hit_mif;

  assign hit_xte = bus_err & ee;
  assign hit_bo  = bo_cross | (page_vle & page_le);
  assign hit_mif = cof_odd & ~page_vle;

  always_comb begin
    if (acc_viol)     cause = CAUSE_ACC;
    else if (hit_xte) cause = CAUSE_XTE;
    else if (hit_bo)  cause = CAUSE_BO;
    else if (hit_mif) cause = CAUSE_MIF;
    else              cause = CAUSE_NONE;
  end
endmodule

// File: rtl/stg_syndrome.sv
module stg_syndrome
  import stg_irq_pkg::*;
(
  input  cause_e            cause,
  input  logic              is_data,
  input  logic              store,
  input  logic              vle_insn,
  output logic [XLEN-1:0]   esr
);
  always_comb begin
    esr          = '0;
    esr[ESR_VLI] = vle_insn;
    esr[ESR_ST]  = is_data & store;
    unique case (cause)
      CAUSE_XTE: esr[ESR_XTE] = 1'b1;
      CAUSE_BO:  esr[ESR_BO]  = 1'b1;
      CAUSE_MIF: esr[ESR_MIF] = 1'b1;
      default:   ;
    endcase
  end
endmodule

// File: rtl/stg_vec_gen.sv
module stg_vec_gen
  import stg_irq_pkg::*;
#(
  parameter int ALIGN_BITS = OFS_LO
) (
  input  logic [XLEN-1:0] prefix,
  input  logic [XLEN-1:0] offset,
  output logic [XLEN-1:0] vec
);
  localparam int OFS_W = PFX_LO - ALIGN_BITS;

  generate
    if (ALIGN_BITS > 0) begin : g_align
      assign vec = {prefix[XLEN-1:PFX_LO], offset[PFX_LO-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    end else begin : g_noalign
      assign vec = {prefix[XLEN-1:PFX_LO], offset[OFS_W-1:0]};
    end
  endgenerate
endmodule

// File: rtl/stg_irq_entry.sv
module stg_irq_entry
  import stg_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            i_vld,
  input  logic            i_acc_viol,
  input  logic            i_bus_err,
  input  logic            i_bo_cross,
  input  logic            i_page_vle,
  input  logic            i_page_le,
  input  logic            i_cof_odd,
  input  logic            i_vle_insn,
  input  logic            d_vld,
  input  logic            d_acc_viol,
  input  logic            d_bo_fault,
  input  logic            d_store,
  input  logic            d_vle_insn,
  input  logic [31:0]     d_ea,
  input  logic [31:0]     msr_in,
  input  logic [31:0]     ivpr,
  input  logic [31:0]     ivor_dsi,
  input  logic [31:0]     ivor_isi,
  output logic            taken,
  output logic            took_data,
  output logic [31:0]     vector,
  output logic [31:0]     msr_out,
  output logic [31:0]     esr_out,
  output logic [31:0]     dear_out
);
  localparam logic [XLEN-1:0] CLR_MASK = msr_clr_mask();

  cause_e          i_cause, d_cause, sel_cause;
  logic            i_hit, d_hit, any_hit;
  logic [XLEN-1:0] vec_isi, vec_dsi, esr_nxt, msr_nxt;

  stg_isi_prio u_prio (
    .ee       (msr_in[MSR_EE]),
    .acc_viol (i_acc_viol),
    .bus_err  (i_bus_err),
    .bo_cross (i_bo_cross),
    .page_vle (i_page_vle),
    .page_le  (i_page_le),
    .cof_odd  (i_cof_odd),
    .cause    (i_cause)
  );

  always_comb begin
    if (d_acc_viol)      d_cause = CAUSE_ACC;
    else if (d_bo_fault) d_cause = CAUSE_BO;
    else                 d_cause = CAUSE_NONE;
  end

  assign d_hit     = d_vld & (d_cause != CAUSE_NONE);
  assign i_hit     = i_vld & (i_cause != CAUSE_NONE);
  assign any_hit   = d_hit | i_hit;
  assign sel_cause = d_hit ? d_cause : i_cause;

  stg_syndrome u_syn (
    .cause    (sel_cause),
    .is_data  (d_hit),
    .store    (d_store),
    .vle_insn (d_hit ? d_vle_insn : i_vle_insn),
    .esr      (esr_nxt)
  );

  stg_vec_gen u_vec_isi (.prefix(ivpr), .offset(ivor_isi), .vec(vec_isi));
  stg_vec_gen u_vec_dsi (.prefix(ivpr), .offset(ivor_dsi), .vec(vec_dsi));

  assign msr_nxt = msr_in & ~CLR_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      taken     <= 1'b0;
      took_data <= 1'b0;
      vector    <= '0;
      msr_out   <= '0;
      esr_out   <= '0;
      dear_out  <= '0;
    end else begin
      taken <= any_hit;
      if (any_hit) begin
        took_data <= d_hit;
        vector    <= d_hit ? vec_dsi : vec_isi;
        msr_out   <= msr_nxt;
        esr_out   <= esr_nxt;
      end
      if (d_hit) dear_out <= d_ea;
    end
  end
endmodule

// File: rtl/stg_irq_entry_chk.sv
module stg_irq_entry_chk
  import stg_irq_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        i_vld,
  input logic        d_vld,
  input logic [31:0] d_ea,
  input logic [31:0] msr_in,
  input logic [31:0] ivpr,
  input logic        taken,
  input logic        took_data,
  input logic [31:0] vector,
  input logic [31:0] msr_out,
  input logic [31:0] esr_out,
  input logic [31:0] dear_out
);
  AST_TAKEN_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    taken |-> $past(i_vld | d_vld));  // R11
  AST_VEC_PREFIX: assert property (@(posedge clk) disable iff (rst)
    taken |-> vector[31:16] == $past(ivpr[31:16]));  // R1
  AST_ME_KEPT: assert property (@(posedge clk) disable iff (rst)
    taken |-> msr_out[MSR_ME] == $past(msr_in[MSR_ME]));  // R8
  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    taken |-> $onehot0({esr_out[ESR_BO], esr_out[ESR_MIF], esr_out[ESR_XTE]}));  // R6
  AST_XTE_NEEDS_EE: assert property (@(posedge clk) disable iff (rst)
    (taken && esr_out[ESR_XTE]) |-> $past(msr_in[MSR_EE]));  // R3
  AST_DEAR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (taken && took_data) |-> dear_out == $past(d_ea));  // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(i_vld || d_vld) |=> (!taken && $stable(vector) && $stable(msr_out) && $stable(esr_out) && $stable(dear_out)));  // R12
  AST_ST_DATA_ONLY: assert property (@(posedge clk) disable iff (rst)
    (taken && !took_data) |-> !esr_out[ESR_ST]);  // R7
endmodule

bind stg_irq_entry stg_irq_entry_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .i_vld     (i_vld),
  .d_vld     (d_vld),
  .d_ea      (d_ea),
  .msr_in    (msr_in),
  .ivpr      (ivpr),
  .taken     (taken),
  .took_data (took_data),
  .vector    (vector),
  .msr_out   (msr_out),
  .esr_out   (esr_out),
  .dear_out  (dear_out)
);

// File: tb/tb_stg_irq_entry.sv
module tb_stg_irq_entry;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam logic [31:0] CLR = 32'h0604_EB32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic i_vld, i_acc_viol, i_bus_err, i_bo_cross, i_page_vle, i_page_le, i_cof_odd, i_vle_insn;
  logic d_vld, d_acc_viol, d_bo_fault, d_store, d_vle_insn;
  logic [31:0] d_ea, msr_in, ivpr, ivor_dsi, ivor_isi;
  logic taken, took_data;
  logic [31:0] vector, msr_out, esr_out, dear_out;

  int checks = 0;
  int errors = 0;

  logic        e_taken, e_data;
  logic [31:0] e_vec, e_msr, e_esr, e_dear;

  always #(CLK_PERIOD/2) clk = ~clk;

  stg_irq_entry dut (.*);

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  function automatic int isi_cause();
    if (i_acc_viol) return 1;
    if (i_bus_err && msr_in[15]) return 2;
    if (i_bo_cross || (i_page_vle && i_page_le)) return 3;
    if (i_cof_odd && !i_page_vle) return 4;
    return 0;
  endfunction

  task automatic model();
    int ic;
    logic dh, ih;
    ic = isi_cause();
    dh = d_vld && (d_acc_viol || d_bo_fault);
    ih = i_vld && (ic != 0);
    e_taken = dh || ih;
    if (dh) begin
      e_data = 1'b1;
      e_vec  = {ivpr[31:16], ivor_dsi[15:4], 4'h0};
      e_msr  = msr_in & ~CLR;
      e_esr  = 32'h0;
      e_esr[23] = d_store;
      e_esr[5]  = d_vle_insn;
      e_esr[17] = !d_acc_viol && d_bo_fault;
      e_dear = d_ea;
    end else if (ih) begin
      e_data = 1'b0;
      e_vec  = {ivpr[31:16], ivor_isi[15:4], 4'h0};
      e_msr  = msr_in & ~CLR;
      e_esr  = 32'h0;
      e_esr[5] = i_vle_insn;
      e_esr[0]  = (ic == 2);
      e_esr[17] = (ic == 3);
      e_esr[1]  = (ic == 4);
    end
  endtask

  // Called at a negedge with inputs already set
  task automatic step(string tag);
    @(posedge clk);
    @(negedge clk);
    model();
    chk(tag, "taken R11 R12", {31'b0, taken}, {31'b0, e_taken});
    chk(tag, "side R10", {31'b0, took_data}, {31'b0, e_data});
    chk(tag, "vector R1", vector, e_vec);
    chk(tag, "msr R8", msr_out, e_msr);
    chk(tag, "esr R7", esr_out, e_esr);
    chk(tag, "dear R9", dear_out, e_dear);
  endtask

  task automatic idle_inputs();
    {i_vld, i_acc_viol, i_bus_err, i_bo_cross, i_page_vle, i_page_le, i_cof_odd, i_vle_insn} = '0;
    {d_vld, d_acc_viol, d_bo_fault, d_store, d_vle_insn} = '0;
  endtask

  task automatic randomize_regs();
    d_ea = $urandom; msr_in = $urandom; ivpr = $urandom;
    ivor_dsi = $urandom; ivor_isi = $urandom;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    idle_inputs();
    randomize_regs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    e_taken = 0; e_data = 0; e_vec = 0; e_msr = 0; e_esr = 0; e_dear = 0;
    chk("R13", "reset taken", {31'b0, taken}, 32'h0);
    chk("R13", "reset vector", vector, 32'h0);
    chk("R13", "reset msr", msr_out, 32'h0);
    chk("R13", "reset esr", esr_out, 32'h0);
    chk("R13", "reset dear", dear_out, 32'h0);
    rst = 1'b0;

    // R2 access control
    randomize_regs(); i_vld = 1; i_acc_viol = 1; i_vle_insn = 1; step("R2");
    idle_inputs();
    // R3 bus error with EE set, then cleared
    randomize_regs(); msr_in[15] = 1; i_vld = 1; i_bus_err = 1; step("R3");
    randomize_regs(); msr_in[15] = 0; i_vld = 1; i_bus_err = 1; step("R3");
    idle_inputs();
    // R4 both byte-ordering cases
    randomize_regs(); i_vld = 1; i_bo_cross = 1; step("R4");
    idle_inputs();
    randomize_regs(); i_vld = 1; i_page_vle = 1; i_page_le = 1; step("R4");
    idle_inputs();
    // R5 misaligned on plain page, ignored on variable-length page
    randomize_regs(); i_vld = 1; i_cof_odd = 1; step("R5");
    randomize_regs(); i_page_vle = 1; step("R5");
    idle_inputs();
    // R6 all causes at once, then without access control
    randomize_regs(); msr_in[15] = 1;
    {i_vld, i_acc_viol, i_bus_err, i_bo_cross, i_cof_odd} = '1; step("R6");
    i_acc_viol = 0; step("R6");
    i_bus_err = 0; step("R6");
    idle_inputs();
    // R9 data faults
    randomize_regs(); d_vld = 1; d_bo_fault = 1; d_store = 1; step("R9");
    randomize_regs(); d_acc_viol = 1; d_vle_insn = 1; step("R9");
    idle_inputs();
    // R10 both sides qualify together
    randomize_regs(); d_vld = 1; d_bo_fault = 1; i_vld = 1; i_cof_odd = 1; step("R10");
    idle_inputs();
    // R12 causes present without strobes
    randomize_regs(); {i_acc_viol, d_acc_viol, d_bo_fault} = '1; step("R12");
    idle_inputs();

    for (int n = 0; n < 400; n++) begin
      randomize_regs();
      i_vld = $urandom_range(0, 1); d_vld = ($urandom_range(0, 3) == 0);
      i_acc_viol = ($urandom_range(0, 4) == 0);
      i_bus_err  = ($urandom_range(0, 3) == 0);
      i_bo_cross = ($urandom_range(0, 4) == 0);
      i_page_vle = $urandom_range(0, 1);
      i_page_le  = ($urandom_range(0, 3) == 0);
      i_cof_odd  = ($urandom_range(0, 3) == 0);
      i_vle_insn = $urandom_range(0, 1);
      d_acc_viol = ($urandom_range(0, 3) == 0);
      d_bo_fault = ($urandom_range(0, 3) == 0);
      d_store    = $urandom_range(0, 1);
      d_vle_insn = $urandom_range(0, 1);
      step("R11");
    end
    summary();
  end
endmodule